// File: doc/BRIEF.md
# Real-Time Monitor Serial Streamer

This block sends four 32-bit monitor words out on one data wire, one bit per cycle of the fast sample clock. A one-cycle pulse from the measurement sequencer marks the start of a frame. On that pulse the block captures all four parallel words into a private copy. It then sends a burst made of four groups. Each group is a high marker bit followed by the 32 bits of one word, least significant bit first, so the sign bit comes last in its group.

A capture clock is driven next to the data so that an external probe can record the stream. The capture clock falls when the data changes and rises in the middle of each bit. The burst always occupies a fixed window of 140 cycles, and the last cycles of that window are low padding. This keeps it inside one processing pass. A busy flag covers the whole window. A frame pulse that arrives during the window is ignored.

Top module: `mon_serial_stream`

## Requirements
- R1: A burst carries four words in ascending order: word k is `words_in[32k+31:32k]`, and it is sent in slot group k (slots 33k to 33k+32).
- R2: Every word group starts with one marker slot in which `ser_out` is 1, so each word uses 33 slots.
- R3: Inside a group, slot j (1..32) carries bit j-1 of the word: least significant bit first, bit 31 (the sign) last.
- R4: When `frame_start` is high at a clock edge and the block is idle, `busy` rises and slot 0 is driven in the cycle that follows that edge. Each later slot takes one clock cycle.
- R5: While `busy` is low, `ser_out` is 0.
- R6: `busy` stays high for exactly 140 cycles. In slots 132 to 139, `ser_out` is 0.
- R7: A `frame_start` pulse while `busy` is high has no effect on the output stream or on the window length.
- R8: The four words are captured on the accepted frame pulse. Later changes on `words_in` do not alter the burst in flight.
- R9: `cap_clk` equals the inverse of `clk` during slots 0 to 131 and is 0 at every other time. Data therefore changes on its falling edge and is stable at its rising edge.
- R10: A synchronous active-high `rst` makes `busy` and `ser_out` 0 after the next edge and aborts any burst. A following frame pulse restarts from slot 0.
- R11: A frame pulse in the first cycle after `busy` falls is accepted, so bursts can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock, one bit slot per period |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Sequencer frame-start pulse |
| words_in | input | 128 | Four monitor words, word k at bits 32k+31:32k |
| ser_out | output | 1 | Serial data line |
| cap_clk | output | 1 | Capture clock for an external probe |
| busy | output | 1 | High during the 140-cycle burst window |

## Verification
A slot counter that drifts by one shows up as a marker bit in the wrong position. It also shifts every data bit in the word groups that follow, so the first mismatch appears within 33 cycles of the fault. A window-length error shows at the end of the burst, as `busy` or `cap_clk` changing on the wrong cycle. A shadow copy that is loaded at the wrong time shows only when `words_in` changes during a burst, so the stimulus deliberately changes the source words and pulses `frame_start` partway through a burst.

// File: rtl/mon_stream_pkg.sv
package mon_stream_pkg;

  // number of bit slots taken by one word including its marker
  function automatic int group_slots(input int word_w);
    return word_w + 1;
  endfunction

  // number of slots that carry marker or data in one burst
  function automatic int active_slots(input int word_w, input int n_words);
    return n_words * group_slots(word_w);
  endfunction

  // bits needed to count from 0 to n inclusive
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/mon_frame_timer.sv
module mon_frame_timer #(
  parameter int FRAME_CYCLES = 140
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  output logic busy,
  output logic start_acc,
  output logic last_cyc
);
  localparam int CW = mon_stream_pkg::cnt_bits(FRAME_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(FRAME_CYCLES - 1);

  logic [CW-1:0] cyc_q;

  assign start_acc = start_req & ~busy;
  assign last_cyc  = busy & (cyc_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cyc_q <= '0;
    end else if (start_acc) begin
      busy  <= 1'b1;
      cyc_q <= '0;
    end else if (last_cyc) begin
      busy  <= 1'b0;
      cyc_q <= '0;
    end else if (busy) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/mon_slot_seq.sv
module mon_slot_seq #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_acc,
  input  logic last_cyc,
  input  logic busy,
  output logic [mon_stream_pkg::cnt_bits(NUM_WORDS)-1:0] word_idx,
  output logic [mon_stream_pkg::cnt_bits(WORD_W)-1:0]    bit_idx,
  output logic slot_active,
  output logic group_end
);
  localparam int WW = mon_stream_pkg::cnt_bits(NUM_WORDS);
  localparam int BW = mon_stream_pkg::cnt_bits(WORD_W);
  localparam logic [BW-1:0] BIT_LAST = BW'(WORD_W);
  localparam logic [WW-1:0] N_W      = WW'(NUM_WORDS);

  assign slot_active = busy & (word_idx < N_W);
  assign group_end   = slot_active & (bit_idx == BIT_LAST);

  always_ff @(posedge clk) begin
    if (rst || start_acc || last_cyc) begin
      word_idx <= '0;
      bit_idx  <= '0;
    end else if (group_end) begin
      word_idx <= word_idx + 1'b1;
      bit_idx  <= '0;
    end else if (slot_active) begin
      bit_idx <= bit_idx + 1'b1;
    end
  end
endmodule

// File: rtl/mon_word_shadow.sv
module mon_word_shadow #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic [NUM_WORDS*WORD_W-1:0] src,
  output logic [NUM_WORDS*WORD_W-1:0] shadow_q
);
  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)       shadow_q[k*WORD_W +: WORD_W] <= '0;
      else if (load) shadow_q[k*WORD_W +: WORD_W] <= src[k*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/mon_serial_stream.sv
module mon_serial_stream #(
  parameter int WORD_W       = 32,
  parameter int NUM_WORDS    = 4,
  parameter int FRAME_CYCLES = 140
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic [NUM_WORDS*WORD_W-1:0] words_in,
  output logic ser_out,
  output logic cap_clk,
  output logic busy
);
  localparam int WW = mon_stream_pkg::cnt_bits(NUM_WORDS);
  localparam int BW = mon_stream_pkg::cnt_bits(WORD_W);

  logic start_acc, last_cyc, slot_active, group_end;
  logic [WW-1:0] word_idx;
  logic [BW-1:0] bit_idx;
  logic [NUM_WORDS*WORD_W-1:0] shadow_q;
  logic data_bit;

  mon_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start_req(frame_start),
    .busy(busy), .start_acc(start_acc), .last_cyc(last_cyc)
  );

  mon_slot_seq #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_seq (
    .clk(clk), .rst(rst), .start_acc(start_acc), .last_cyc(last_cyc),
    .busy(busy), .word_idx(word_idx), .bit_idx(bit_idx),
    .slot_active(slot_active), .group_end(group_end)
  );

  mon_word_shadow #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_shadow (
    .clk(clk), .rst(rst), .load(start_acc), .src(words_in), .shadow_q(shadow_q)
  );

  // slot 0 of a group is the marker, slot j carries bit j-1
  always_comb begin
    data_bit = 1'b0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      for (int b = 0; b < WORD_W; b++) begin
        if (word_idx == WW'(k) && bit_idx == BW'(b + 1))
          data_bit = shadow_q[k*WORD_W + b];
      end
    end
  end

  assign ser_out = slot_active & ((bit_idx == '0) | data_bit);
  assign cap_clk = slot_active & ~clk;
endmodule

// File: rtl/mon_stream_check.sv
module mon_stream_check #(
  parameter int WORD_W       = 32,
  parameter int NUM_WORDS    = 4,
  parameter int FRAME_CYCLES = 140
) (
  input logic clk,
  input logic rst,
  input logic frame_start,
  input logic ser_out,
  input logic busy,
  input logic last_cyc,
  input logic start_acc,
  input logic slot_active,
  input logic [mon_stream_pkg::cnt_bits(WORD_W)-1:0] bit_idx,
  input logic [NUM_WORDS*WORD_W-1:0] shadow_q
);
  localparam int BW = mon_stream_pkg::cnt_bits(WORD_W);

  a_r5_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ser_out);

  a_r2_marker_high: assert property (@(posedge clk) disable iff (rst)
    (slot_active && bit_idx == '0) |-> ser_out);

  a_r6_pad_low: assert property (@(posedge clk) disable iff (rst)
    (busy && !slot_active) |-> !ser_out);

  a_r6_window_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_cyc) |=> busy);

  a_r6_window_ends: assert property (@(posedge clk) disable iff (rst)
    last_cyc |=> !busy);

  a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && frame_start) |-> !start_acc);

  a_r8_shadow_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(shadow_q));

  a_r3_bit_range: assert property (@(posedge clk) disable iff (rst)
    bit_idx <= BW'(WORD_W));

  a_r4_start_rises: assert property (@(posedge clk) disable iff (rst)
    start_acc |=> (busy && slot_active && bit_idx == '0));
endmodule

bind mon_serial_stream mon_stream_check #(
  .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .FRAME_CYCLES(FRAME_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .ser_out(ser_out),
  .busy(busy), .last_cyc(last_cyc), .start_acc(start_acc),
  .slot_active(slot_active), .bit_idx(bit_idx), .shadow_q(shadow_q)
);

// File: tb/mon_serial_stream_test.sv
`timescale 1ns/1ps
module mon_serial_stream_test;
  localparam int WORD_W = 32;
  localparam int NW     = 4;
  localparam int FRAME  = 140;
  localparam int GROUP  = WORD_W + 1;
  localparam int ACTIVE = NW * GROUP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0;
  logic [NW*WORD_W-1:0] words_in = '0;
  logic ser_out, cap_clk, busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  mon_serial_stream #(.WORD_W(WORD_W), .NUM_WORDS(NW), .FRAME_CYCLES(FRAME)) uut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .words_in(words_in),
    .ser_out(ser_out), .cap_clk(cap_clk), .busy(busy)
  );

  task automatic check(input string req, input logic act, input logic exp, input int slot);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s slot %0d: actual=%b expected=%b", req, slot, act, exp);
    end
  endtask

  // expected line level for slot s of a burst carrying w
  function automatic logic exp_bit(input logic [NW*WORD_W-1:0] w, input int s);
    int g, j;
    if (s >= ACTIVE) return 1'b0;
    g = s / GROUP;
    j = s % GROUP;
    if (j == 0) return 1'b1;
    return w[g*WORD_W + j - 1];
  endfunction

  task automatic idle_check(input string req);
    check(req, busy, 1'b0, -1);
    check("R5", ser_out, 1'b0, -1);
    check("R9", cap_clk, 1'b0, -1);
  endtask

  // runs at clk low; samples in the low phase of each slot
  task automatic burst(input logic [NW*WORD_W-1:0] w, input bit disturb);
    logic [NW*WORD_W-1:0] exp_w;
    exp_w = w;
    words_in = w;
    frame_start = 1'b1;
    @(negedge clk); #1;
    frame_start = 1'b0;
    for (int s = 0; s < FRAME; s++) begin
      if (s == 0) check("R4", busy, 1'b1, s);
      else        check("R6", busy, 1'b1, s);
      if (s < ACTIVE && s % GROUP == 0) check("R2", ser_out, exp_bit(exp_w, s), s);
      else if (s < ACTIVE)              check("R3", ser_out, exp_bit(exp_w, s), s);
      else                              check("R6", ser_out, 1'b0, s);
      check("R9", cap_clk, (s < ACTIVE) ? 1'b1 : 1'b0, s);
      if (disturb && s == 10) words_in = ~w;            // R8
      if (disturb && (s == 20 || s == FRAME - 1)) frame_start = 1'b1;  // R7
      @(negedge clk); #1;
      frame_start = 1'b0;
    end
    idle_check("R6");
  endtask

  initial begin : watchdog
    while (cycles < 100000) @(posedge clk) cycles++;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    #1;
    idle_check("R10");
    rst = 1'b0;
    @(negedge clk); #1;
    idle_check("R5");

    // R1 R3: distinct per-word patterns
    burst({32'h89AB_CDEF, 32'h0123_4567, 32'hFFFF_0000, 32'h8000_0001}, 1'b0);
    // R11: back to back, all zeros then all ones
    burst('0, 1'b0);
    burst('1, 1'b0);
    // walking one across each word: R3 bit order
    for (int b = 0; b < WORD_W; b += 5)
      burst({NW{32'(1) << b}}, 1'b0);
    // R7 R8: source change and stray pulses mid-burst
    burst({32'hDEAD_BEEF, 32'h1357_9BDF, 32'h2468_ACE0, 32'h7FFF_FFFE}, 1'b1);
    repeat (3) begin @(negedge clk); #1; idle_check("R7"); end

    // R10: reset in the middle of a burst
    words_in = {NW{32'hA5A5_5A5A}};
    frame_start = 1'b1;
    @(negedge clk); #1;
    frame_start = 1'b0;
    repeat (50) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); #1;
    idle_check("R10");
    rst = 1'b0;
    @(negedge clk); #1;
    idle_check("R10");
    burst({32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h3333_CCCC, 32'h5555_AAAA}, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule